// File: doc/BRIEF.md
# Serial Hold and Sleep Controller

This block sits beside the command engine of a serial memory slave and manages two things that interrupt normal traffic. The first is an active-low pause input: while chip select is low, pulling it low suspends the current transfer without ending it. The block freezes the engine, forces the serial output to high impedance and records the clock level seen at that moment. The pause only ends when the pause input is high and the serial clock is back at that recorded level. If chip select rises during a pause, the transfer is dropped and a one-cycle abort pulse tells the engine to discard it.

The second is a low-power sleep state. The command engine pulses `sleep_op` once it has decoded the sleep opcode. The block then arms, and it enters sleep on the following rise of chip select, unless any serial clock rising edge arrives before that rise. While asleep, or while waking, every serial input is ignored and the output stays at high impedance. A fall of chip select starts a recovery timer. The timer runs on the system clock for `REC_CYCLES` cycles, and `ready` returns when it completes. If chip select falls again during recovery, the timer is not restarted and a sticky error flag is set.

All pins are sampled on the system clock (`clk`). `cs_n`, `sck` and `hold_n` are expected to be synchronous to it, or already synchronised by the instantiating logic. There is no data stream here, only control levels and pulses.

Top module: `hold_sleep_ctrl`

## Requirements
- R1: Out of reset: `pause`=0, `so_hiz`=0, `abort`=0, `ready`=1, `asleep`=0, `wake_err`=0.
- R2: When `ready`=1, `cs_n`=0 and `hold_n`=0 are sampled at a clock edge, `pause` and `so_hiz` are 1 after that edge. The `sck` level sampled at that edge is recorded. With `cs_n`=1, a low `hold_n` has no effect.
- R3: A held state ends after the first edge at which `hold_n`=1 and `sck` equals the recorded level. If `hold_n` is high but `sck` is at the other level, the block stays held. Toggling `sck` while `hold_n`=0 does not end the hold.
- R4: If `cs_n`=1 is sampled while held, `pause` clears after that edge and `abort` is 1 for exactly one cycle.
- R5: A `sleep_op` pulse sampled with `cs_n`=0 arms sleep. The next edge that samples `cs_n`=1 enters sleep: `asleep`=1, `ready`=0, `pause`=1, `so_hiz`=1.
- R6: A rising edge of `sck` (sampled 0 then 1) while armed cancels the arming, so a later `cs_n` rise leaves `asleep`=0 and `ready`=1.
- R7: While asleep with `cs_n` high, activity on `sck`, `hold_n` and `sleep_op` leaves `asleep`=1 and has no effect on the later wake timing.
- R8: A fall of `cs_n` (sampled 1 then 0) while asleep clears `asleep` and starts recovery. `ready` is 1 exactly `REC_CYCLES` edges after the edge that sampled the fall. `cs_n` may return high during recovery without changing this.
- R9: A further `cs_n` fall during recovery sets `wake_err`, which stays set until reset, and does not delay `ready`.
- R10: While `ready`=0, `hold_n` is ignored: a `cs_n` rise with `hold_n` low never produces `abort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also times recovery |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock level |
| hold_n | input | 1 | Pause request, active low |
| sleep_op | input | 1 | One-cycle pulse: sleep opcode decoded |
| pause | output | 1 | Freeze the command engine |
| so_hiz | output | 1 | Force the serial output to high impedance |
| abort | output | 1 | One-cycle pulse: drop the paused transfer |
| ready | output | 1 | Commands may be accepted |
| asleep | output | 1 | Sleep state, before any wake request |
| wake_err | output | 1 | Sticky: chip select fell during recovery |

## Verification
Every output is registered, so each result appears after the system-clock edge that samples its cause. The bench changes inputs on the falling edge, then checks on the next falling edge, which is one edge later. The exception is `ready`: after a chip-select fall it is due `REC_CYCLES` edges later. The bench counts that window edge by edge and checks that `ready` is low on each edge before the last and high on the last. It sweeps every combination of recorded clock level against release clock level, and it repeats the recovery count with and without a second chip-select fall inside the window.

// File: rtl/hold_sleep_pkg.sv
package hold_sleep_pkg;
  typedef enum logic [1:0] {
    SL_RUN   = 2'd0,
    SL_ARMED = 2'd1,
    SL_DOZE  = 2'd2,
    SL_WAKE  = 2'd3
  } slp_state_t;
endpackage

// File: rtl/hs_hold_track.sv
module hs_hold_track (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  output logic held,
  output logic abort
);
  logic lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= 1'b0;
      lvl   <= 1'b0;
      abort <= 1'b0;
    end else begin
      abort <= 1'b0;
      if (held) begin
        if (cs_n) begin
          held  <= 1'b0;
          abort <= 1'b1;
        end else if (hold_n && (sck == lvl)) begin
          held <= 1'b0;
        end
      end else if (en && !cs_n && !hold_n) begin
        held <= 1'b1;
        lvl  <= sck;
      end
    end
  end

  // R4: abort is a single pulse and the hold is gone when it appears
  a_r4_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!held ##1 !abort));

  // R3: release without chip select rise only with pause high
  a_r3_release_needs_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(held) && !abort) |-> $past(hold_n));
endmodule

// File: rtl/hs_wake_timer.sv
module hs_wake_timer #(
  parameter int unsigned REC_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (REC_CYCLES > 1) ? $clog2(REC_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(REC_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= '0;
    end else if (run && cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = run && (cnt == LAST);

  // R8: the count never passes its limit while running
  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= LAST));
endmodule

// File: rtl/hs_sleep_fsm.sv
module hs_sleep_fsm
  import hold_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       sleep_op,
  input  logic       held,
  input  logic       tmr_done,
  output logic       tmr_start,
  output logic       tmr_run,
  output slp_state_t state,
  output logic       wake_err
);
  logic cs_q, sck_q;
  logic cs_fall, sck_rise;

  assign cs_fall   = cs_q && !cs_n;
  assign sck_rise  = !sck_q && sck;
  assign tmr_start = (state == SL_DOZE) && cs_fall;
  assign tmr_run   = (state == SL_WAKE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      sck_q    <= 1'b0;
      state    <= SL_RUN;
      wake_err <= 1'b0;
    end else begin
      cs_q  <= cs_n;
      sck_q <= sck;
      case (state)
        SL_RUN:   if (sleep_op && !cs_n && !held) state <= SL_ARMED;
        SL_ARMED: if (cs_n) state <= SL_DOZE;
                  else if (sck_rise) state <= SL_RUN;
        SL_DOZE:  if (cs_fall) state <= SL_WAKE;
        SL_WAKE: begin
          if (tmr_done) state <= SL_RUN;
          if (cs_fall) wake_err <= 1'b1;
        end
        default:  state <= SL_RUN;
      endcase
    end
  end

  // R9: the error flag never clears
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wake_err) |-> wake_err);

  // R5: sleep is only reached from the armed state
  a_r5_doze_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SL_DOZE && $past(state) != SL_DOZE) |-> $past(state) == SL_ARMED);

  // R8: leaving recovery only when the timer reported completion
  a_r8_wake_exit_timed: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == SL_WAKE && state != SL_WAKE) |-> $past(tmr_done));
endmodule

// File: rtl/hold_sleep_ctrl.sv
module hold_sleep_ctrl
  import hold_sleep_pkg::*;
#(
  parameter int unsigned REC_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  input  logic sleep_op,
  output logic pause,
  output logic so_hiz,
  output logic abort,
  output logic ready,
  output logic asleep,
  output logic wake_err
);
  slp_state_t state;
  logic held, tmr_start, tmr_run, tmr_done;

  hs_hold_track u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (ready),
    .cs_n   (cs_n),
    .sck    (sck),
    .hold_n (hold_n),
    .held   (held),
    .abort  (abort)
  );

  hs_sleep_fsm u_sleep (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sck       (sck),
    .sleep_op  (sleep_op),
    .held      (held),
    .tmr_done  (tmr_done),
    .tmr_start (tmr_start),
    .tmr_run   (tmr_run),
    .state     (state),
    .wake_err  (wake_err)
  );

  hs_wake_timer #(.REC_CYCLES(REC_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .run   (tmr_run),
    .done  (tmr_done)
  );

  assign ready  = (state == SL_RUN) || (state == SL_ARMED);
  assign asleep = (state == SL_DOZE);
  assign pause  = held || !ready;
  assign so_hiz = pause;

  // R10: a pause is never active outside the ready state
  a_r10_no_hold_when_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    !(held && !ready));

  // R10: no abort can come out of sleep or recovery
  a_r10_no_abort_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ready) && !ready) |-> !abort);
endmodule

// File: tb/tb_hold_sleep_ctrl.sv
module tb_hold_sleep_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, sleep_op = 1'b0;
  logic pause, so_hiz, abort, ready, asleep, wake_err;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hold_sleep_ctrl #(.REC_CYCLES(N)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .sleep_op(sleep_op), .pause(pause), .so_hiz(so_hiz), .abort(abort),
    .ready(ready), .asleep(asleep), .wake_err(wake_err)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic enter_sleep();
    cs_n = 1'b0; sleep_op = 1'b1; tick();
    sleep_op = 1'b0; cs_n = 1'b1; tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset values
    chk("R1 pause", pause, 1'b0);
    chk("R1 so_hiz", so_hiz, 1'b0);
    chk("R1 abort", abort, 1'b0);
    chk("R1 ready", ready, 1'b1);
    chk("R1 asleep", asleep, 1'b0);
    chk("R1 wake_err", wake_err, 1'b0);
    rst_n = 1'b1; tick();

    // R2 hold ignored with chip select high
    cs_n = 1'b1; hold_n = 1'b0; tick();
    chk("R2 cs high ignores hold", pause, 1'b0);
    hold_n = 1'b1; tick();

    // R2/R3 sweep of recorded level against release level
    for (int l = 0; l < 2; l++) begin
      for (int e = 0; e < 2; e++) begin
        cs_n = 1'b0; sck = l[0]; hold_n = 1'b0; tick();
        chk("R2 pause on hold", pause, 1'b1);
        chk("R2 so_hiz on hold", so_hiz, 1'b1);
        for (int t = 0; t < 3; t++) begin
          sck = ~sck; tick();
          chk("R3 sck toggles while held", pause, 1'b1);
        end
        sck = e[0]; hold_n = 1'b1; tick();
        chk("R3 release by level", pause, (e != l) ? 1'b1 : 1'b0);
        if (e != l) begin
          sck = l[0]; tick();
          chk("R3 late release at recorded level", pause, 1'b0);
        end
        chk("R3 no abort on release", abort, 1'b0);
        cs_n = 1'b1; sck = 1'b0; tick();
      end
    end

    // R4 abort on chip select rise while held
    cs_n = 1'b0; sck = 1'b1; hold_n = 1'b0; tick();
    cs_n = 1'b1; tick();
    chk("R4 abort pulse", abort, 1'b1);
    chk("R4 pause cleared", pause, 1'b0);
    tick();
    chk("R4 abort one cycle", abort, 1'b0);
    hold_n = 1'b1; sck = 1'b0; tick();

    // R6 cancel by a clock rise while armed
    cs_n = 1'b0; sleep_op = 1'b1; tick();
    sleep_op = 1'b0; sck = 1'b1; tick();
    sck = 1'b0; cs_n = 1'b1; tick();
    chk("R6 cancelled asleep", asleep, 1'b0);
    chk("R6 cancelled ready", ready, 1'b1);

    // R5 sleep entry
    enter_sleep();
    chk("R5 asleep", asleep, 1'b1);
    chk("R5 ready low", ready, 1'b0);
    chk("R5 pause", pause, 1'b1);
    chk("R5 so_hiz", so_hiz, 1'b1);

    // R7 activity while asleep
    for (int t = 0; t < 6; t++) begin
      sck = ~sck; hold_n = t[0]; sleep_op = t[1]; tick();
      chk("R7 stays asleep", asleep, 1'b1);
    end
    sck = 1'b0; hold_n = 1'b1; sleep_op = 1'b0;

    // R8 wake timing, with chip select returning high mid-way
    cs_n = 1'b0; tick();
    chk("R8 asleep cleared", asleep, 1'b0);
    for (int i = 1; i <= N; i++) begin
      if (i == 2) cs_n = 1'b1;
      tick();
      chk("R8 ready timing", ready, (i == N) ? 1'b1 : 1'b0);
    end
    chk("R8 no error", wake_err, 1'b0);
    cs_n = 1'b1; tick();

    // R9 and R10: second fall during recovery, hold with chip select rise
    enter_sleep();
    cs_n = 1'b0; tick();
    for (int i = 1; i <= N; i++) begin
      if (i == 1) begin cs_n = 1'b1; hold_n = 1'b0; end
      if (i == 2) cs_n = 1'b0;
      if (i == 4) cs_n = 1'b1;
      if (i == 5) hold_n = 1'b1;
      tick();
      if (i >= 3) chk("R9 error set", wake_err, 1'b1);
      if (i <= 5) chk("R10 no abort while waking", abort, 1'b0);
      chk("R9 ready not delayed", ready, (i == N) ? 1'b1 : 1'b0);
    end
    tick();
    chk("R10 no pause after wake", pause, 1'b0);
    chk("R9 error sticky", wake_err, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule